// File: doc/BRIEF.md
# Multi-Phase Parallel Link Receiver

This block is the receive end of a wide parallel data link between two devices that share one system clock. Every line of the link sees its own board delay. The lines are therefore split into contiguous groups, and each group is sampled on whichever quarter-phase copy of the clock lands nearest the middle of that group's data eye. The block takes the system clock and its 90, 180 and 270 degree copies. It captures each group on its chosen edge, moves the captured bits into the system clock domain, and pads each group with just enough extra registers that the whole bus leaves on one common cycle.

A group's phase is given as an index from -1 to 3. For index i, the sample instant is (1 + i/4) clock periods after the transmitter's launch edge. Index -1 is the 270 degree edge inside the launch cycle itself. Index 3 is the 270 degree edge one cycle later. Both use the same clock copy, but they are aligned with different amounts of padding.

In double-data-rate mode each line carries two bits per cycle. The second bit is taken half a period after the first one, on the opposite phase. A parameter can hold the second bit back by one more cycle before it is output.

Top module: `mphase_link_rx`

## Requirements
- R1: The lines are partitioned into contiguous groups by the parameter arrays GRP_LO, GRP_HI and GRP_PHASE (group g covers lines GRP_LO[g]..GRP_HI[g]). A pattern placed on one group's lines reaches only those output lines. A layout that leaves a gap, overlaps, exceeds 138 lines, or names a phase outside -1..3 is rejected at elaboration.
- R2: A group with phase index i samples its lines at launch + T*(1+i/4). That is the 270 degree edge of the launch cycle for -1, the next clk, clk90 or clk180 edge for 0, 1 or 2, and the 270 degree edge of the following cycle for 3.
- R3: In single-rate mode (DDR=0), the bit launched on clk edge n appears on rise_o after clk edge n+2 and holds until edge n+3, for every group.
- R4: In single-rate mode, fall_o stays 0 whatever the lines carry.
- R5: In double-rate mode, the bit launched half a period after edge n is sampled half a period after the group's first-bit instant, on the opposite phase.
- R6: In double-rate mode with FALL_DELAY=0, both bits launched in cycle n appear after clk edge n+3: the first on rise_o and the second on fall_o.
- R7: With DDR=1 and FALL_DELAY=1, after clk edge n+3 rise_o carries the first bit of cycle n and fall_o carries the second bit of cycle n-1.
- R8: An active-low asynchronous rst_n clears every register. While it is low, rise_o and fall_o are 0, whatever the lines carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 0 degree phase; all outputs are registered on it |
| clk90 | input | 1 | System clock shifted by a quarter period |
| clk180 | input | 1 | System clock shifted by a half period |
| clk270 | input | 1 | System clock shifted by three quarter periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | WIDTH | Link lines from the transmitting device |
| rise_o | output | WIDTH | Aligned word (first bit of each line in double-rate mode) |
| fall_o | output | WIDTH | Second bit of each line in double-rate mode, 0 in single-rate mode |

## Verification
The bench launches each word on a clk edge. It moves every group's lines at the instant that centres that group's eye on its sample edge, so the data changes only on edges of other phases. In single-rate mode, word n is due on rise_o two clk edges after its launch. In double-rate mode both halves are due three edges after launch, and with the extra delay the second half is due four edges after launch. The bench compares the outputs halfway through each clk cycle against the word launched that many cycles earlier, whole-word and group by group. It only compares words whose capture edges all fall after reset is released, and during reset it checks that the outputs are held at zero.

// File: rtl/lrx_pkg.sv
`timescale 1ns/1ps
package lrx_pkg;

    // Number of clock copies, spaced a quarter period apart.
    localparam int QUARTERS  = 4;
    localparam int MAX_LINES = 138;
    localparam int MIN_PHASE = -1;
    localparam int MAX_PHASE = 3;
    localparam int MAX_BAL   = 4;

    // Sample instant, in quarter periods after the launch edge.
    function automatic int sample_quarter(int phase, bit second_half);
        return QUARTERS + phase + (second_half ? QUARTERS / 2 : 0);
    endfunction

    // Which clock copy (0=clk, 1=clk90, 2=clk180, 3=clk270) holds that instant.
    function automatic int clk_index(int q);
        return q % QUARTERS;
    endfunction

    // clk edges after launch at which the bit is first held by a clk register.
    function automatic int arrival_edges(int q);
        return (q + QUARTERS - 1) / QUARTERS;
    endfunction

    // Common output latency: the latest arrival over every phase choice.
    function automatic int base_latency(bit ddr);
        return arrival_edges(sample_quarter(MAX_PHASE, ddr));
    endfunction

endpackage

// File: rtl/lrx_capture.sv
`timescale 1ns/1ps
// Captures one group's lines on a chosen clock copy and brings them into clk.
module lrx_capture #(
    parameter int W = 8,
    parameter int Q = 4
) (
    input  logic [3:0]   phase_clks,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cap_o,
    output logic [W-1:0] ret_o
);
    localparam int SEL    = lrx_pkg::clk_index(Q);
    localparam bit RETIME = (SEL != 0);

    logic cap_clk;
    logic unused_clks;
    assign cap_clk     = phase_clks[SEL];
    assign unused_clks = ^phase_clks;

    logic [W-1:0] cap_d, cap_q;

    always_comb begin
        cap_d = din;
    end

    always_ff @(posedge cap_clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cap_o = cap_q;

    generate
        if (RETIME) begin : g_ret
            logic [W-1:0] ret_d, ret_q;
            always_comb begin
                ret_d = cap_q;
            end
            always_ff @(posedge phase_clks[0] or negedge rst_n) begin
                if (!rst_n) ret_q <= '0;
                else        ret_q <= ret_d;
            end
            assign ret_o = ret_q;
        end else begin : g_direct
            assign ret_o = cap_q;
        end
    endgenerate

endmodule

// File: rtl/lrx_balance.sv
`timescale 1ns/1ps
// Equalising delay line in the clk domain.
module lrx_balance #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (DEPTH < 0 || DEPTH > lrx_pkg::MAX_BAL) begin : g_bad_depth
            $error("lrx_balance: DEPTH out of range");
        end

        if (DEPTH == 0) begin : g_pass
            logic unused_bal;
            assign unused_bal = clk ^ rst_n;
            assign dout = din;
        end else begin : g_pipe
            typedef struct packed {
                logic [DEPTH-1:0][W-1:0] pipe;
                logic [2:0]              since;
            } bal_t;

            bal_t st_d, st_q;

            always_comb begin
                st_d         = st_q;
                st_d.pipe[0] = din;
                for (int k = 1; k < DEPTH; k++) begin
                    st_d.pipe[k] = st_q.pipe[k-1];
                end
                if (st_q.since != 3'd7) st_d.since = st_q.since + 3'd1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign dout = st_q.pipe[DEPTH-1];

            // R8: nothing but zeros leaves before the line has filled after reset
            a_r8_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.since < 3'(DEPTH)) |-> (dout == '0));

            // R3: once filled, the output is the input delayed by DEPTH cycles
            a_r3_chain_latency: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.since >= 3'(DEPTH)) |-> (dout == $past(din, DEPTH)));
        end
    endgenerate

endmodule

// File: rtl/lrx_group.sv
`timescale 1ns/1ps
// One group of lines: capture on its phase, retime, pad to the common latency.
module lrx_group #(
    parameter int W          = 8,
    parameter int PHASE      = 0,
    parameter bit DDR        = 1'b0,
    parameter int FALL_DELAY = 0
) (
    input  logic [3:0]   phase_clks,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    localparam int LAT   = lrx_pkg::base_latency(DDR);
    localparam int Q_R   = lrx_pkg::sample_quarter(PHASE, 1'b0);
    localparam int BAL_R = LAT - lrx_pkg::arrival_edges(Q_R);
    localparam int TOT_R = BAL_R + ((lrx_pkg::clk_index(Q_R) != 0) ? 1 : 0);

    logic clk_sys;
    assign clk_sys = phase_clks[0];

    logic [2:0] since_d, since_q;

    always_comb begin
        since_d = since_q;
        if (since_q != 3'd7) since_d = since_q + 3'd1;
    end

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) since_q <= '0;
        else        since_q <= since_d;
    end

    logic [W-1:0] cap_r, ret_r;

    lrx_capture #(.W(W), .Q(Q_R)) u_cap_r (
        .phase_clks (phase_clks),
        .rst_n      (rst_n),
        .din        (din),
        .cap_o      (cap_r),
        .ret_o      (ret_r)
    );

    lrx_balance #(.W(W), .DEPTH(BAL_R)) u_bal_r (
        .clk   (clk_sys),
        .rst_n (rst_n),
        .din   (ret_r),
        .dout  (rise_o)
    );

    generate
        if (TOT_R > 0) begin : g_chk_r
            // R2: the sampled value reaches rise_o after retime plus padding
            a_r2_rise_path: assert property (@(posedge clk_sys) disable iff (!rst_n)
                (since_q >= 3'(TOT_R)) |-> (rise_o == $past(cap_r, TOT_R)));
        end

        if (DDR) begin : g_fall
            localparam int Q_F   = lrx_pkg::sample_quarter(PHASE, 1'b1);
            localparam int BAL_F = LAT + FALL_DELAY - lrx_pkg::arrival_edges(Q_F);
            localparam int TOT_F = BAL_F + ((lrx_pkg::clk_index(Q_F) != 0) ? 1 : 0);

            logic [W-1:0] cap_f, ret_f;

            lrx_capture #(.W(W), .Q(Q_F)) u_cap_f (
                .phase_clks (phase_clks),
                .rst_n      (rst_n),
                .din        (din),
                .cap_o      (cap_f),
                .ret_o      (ret_f)
            );

            lrx_balance #(.W(W), .DEPTH(BAL_F)) u_bal_f (
                .clk   (clk_sys),
                .rst_n (rst_n),
                .din   (ret_f),
                .dout  (fall_o)
            );

            if (TOT_F > 0) begin : g_chk_f
                // R5: the second-half sample reaches fall_o with its own padding
                a_r5_fall_path: assert property (@(posedge clk_sys) disable iff (!rst_n)
                    (since_q >= 3'(TOT_F)) |-> (fall_o == $past(cap_f, TOT_F)));
            end
        end else begin : g_sdr
            assign fall_o = '0;
        end
    endgenerate

endmodule

// File: rtl/mphase_link_rx.sv
`timescale 1ns/1ps
module mphase_link_rx #(
    parameter int WIDTH             = 64,
    parameter int NGRP              = 2,
    parameter int GRP_LO    [NGRP]  = '{0, 40},
    parameter int GRP_HI    [NGRP]  = '{39, 63},
    parameter int GRP_PHASE [NGRP]  = '{3, 2},
    parameter bit DDR               = 1'b0,
    parameter int FALL_DELAY        = 0
) (
    input  logic             clk,
    input  logic             clk90,
    input  logic             clk180,
    input  logic             clk270,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] line_i,
    output wire  [WIDTH-1:0] rise_o,
    output wire  [WIDTH-1:0] fall_o
);
    logic [3:0] phase_clks;
    assign phase_clks = {clk270, clk180, clk90, clk};

    generate
        if (WIDTH < 1 || WIDTH > lrx_pkg::MAX_LINES) begin : g_bad_width
            $error("mphase_link_rx: WIDTH outside 1..138");
        end
        if (FALL_DELAY < 0 || FALL_DELAY > 1) begin : g_bad_fd
            $error("mphase_link_rx: FALL_DELAY must be 0 or 1");
        end

        // R1: groups must tile the bus in order, without gap or overlap
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            if (GRP_LO[g] > GRP_HI[g]) begin : g_bad_range
                $error("mphase_link_rx: group bounds reversed");
            end
            if (GRP_PHASE[g] < lrx_pkg::MIN_PHASE || GRP_PHASE[g] > lrx_pkg::MAX_PHASE) begin : g_bad_phase
                $error("mphase_link_rx: phase index outside -1..3");
            end
            if (g == 0) begin : g_first
                if (GRP_LO[g] != 0) begin : g_bad_start
                    $error("mphase_link_rx: first group must start at line 0");
                end
            end else begin : g_next
                if (GRP_LO[g] != GRP_HI[g-1] + 1) begin : g_bad_join
                    $error("mphase_link_rx: groups leave a gap or overlap");
                end
            end
            if (g == NGRP - 1) begin : g_last
                if (GRP_HI[g] != WIDTH - 1) begin : g_bad_end
                    $error("mphase_link_rx: last group must end at the top line");
                end
            end

            lrx_group #(
                .W          (GRP_HI[g] - GRP_LO[g] + 1),
                .PHASE      (GRP_PHASE[g]),
                .DDR        (DDR),
                .FALL_DELAY (FALL_DELAY)
            ) u_grp (
                .phase_clks (phase_clks),
                .rst_n      (rst_n),
                .din        (line_i[GRP_HI[g]:GRP_LO[g]]),
                .rise_o     (rise_o[GRP_HI[g]:GRP_LO[g]]),
                .fall_o     (fall_o[GRP_HI[g]:GRP_LO[g]])
            );
        end
    endgenerate

endmodule

// File: tb/tb_mphase_link_rx.sv
`timescale 1ns/1ps
module tb_mphase_link_rx;

    localparam int TW = 40;
    localparam int NG = 5;
    localparam int LO [NG] = '{0, 10, 20, 28, 34};
    localparam int HI [NG] = '{9, 19, 27, 33, 39};
    localparam int PH [NG] = '{-1, 0, 1, 2, 3};
    localparam int NW = 300;
    localparam int TICKS = 4 * (NW + 6);

    logic clk, clk90, clk180, clk270, rst_n;
    logic [TW-1:0] sdr_line, ddr_line;
    wire  [TW-1:0] s_rise, s_fall, d0_rise, d0_fall, d1_rise, d1_fall;

    logic [TW-1:0] tx_s  [NW];
    logic [TW-1:0] tx_dr [NW];
    logic [TW-1:0] tx_df [NW];

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    mphase_link_rx #(.WIDTH(TW), .NGRP(NG), .GRP_LO(LO), .GRP_HI(HI), .GRP_PHASE(PH),
                     .DDR(1'b0), .FALL_DELAY(0)) dut (
        .clk(clk), .clk90(clk90), .clk180(clk180), .clk270(clk270), .rst_n(rst_n),
        .line_i(sdr_line), .rise_o(s_rise), .fall_o(s_fall));

    mphase_link_rx #(.WIDTH(TW), .NGRP(NG), .GRP_LO(LO), .GRP_HI(HI), .GRP_PHASE(PH),
                     .DDR(1'b1), .FALL_DELAY(0)) dut_ddr0 (
        .clk(clk), .clk90(clk90), .clk180(clk180), .clk270(clk270), .rst_n(rst_n),
        .line_i(ddr_line), .rise_o(d0_rise), .fall_o(d0_fall));

    mphase_link_rx #(.WIDTH(TW), .NGRP(NG), .GRP_LO(LO), .GRP_HI(HI), .GRP_PHASE(PH),
                     .DDR(1'b1), .FALL_DELAY(1)) dut_ddr1 (
        .clk(clk), .clk90(clk90), .clk180(clk180), .clk270(clk270), .rst_n(rst_n),
        .line_i(ddr_line), .rise_o(d1_rise), .fall_o(d1_fall));

    function automatic logic [TW-1:0] gmask(int g);
        logic [TW-1:0] m = '0;
        for (int b = LO[g]; b <= HI[g]; b++) m[b] = 1'b1;
        return m;
    endfunction

    function automatic logic [TW-1:0] rnd_word();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [TW-1:0] w_s(int n);
        return (n < 0 || n >= NW) ? '0 : tx_s[n];
    endfunction
    function automatic logic [TW-1:0] w_dr(int n);
        return (n < 0 || n >= NW) ? '0 : tx_dr[n];
    endfunction
    function automatic logic [TW-1:0] w_df(int n);
        return (n < 0 || n >= NW) ? '0 : tx_df[n];
    endfunction

    task automatic chk(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Launch edge of cycle n is tick 4n; group with index i moves its lines so the
    // sample edge at quarter (4+i) sits in the middle of the eye.
    task automatic drive(input int s);
        for (int g = 0; g < NG; g++) begin
            int t;
            t = s - (2 + PH[g]);
            if (t >= 0 && t % 4 == 0)
                for (int b = LO[g]; b <= HI[g]; b++) sdr_line[b] = w_s(t / 4)[b];
            t = s - (3 + PH[g]);
            if (t >= 0 && t % 4 == 0)
                for (int b = LO[g]; b <= HI[g]; b++) ddr_line[b] = w_dr(t / 4)[b];
            t = s - (5 + PH[g]);
            if (t >= 0 && t % 4 == 0)
                for (int b = LO[g]; b <= HI[g]; b++) ddr_line[b] = w_df(t / 4)[b];
        end
    endtask

    // Called halfway through clk cycle k (last clk edge at tick 4k).
    task automatic check_cycle(input int k);
        int n;
        if (rst_n == 1'b0) begin
            chk("R8 reset sdr rise", s_rise, '0);
            chk("R8 reset sdr fall", s_fall, '0);
            chk("R8 reset ddr0 rise", d0_rise, '0);
            chk("R8 reset ddr0 fall", d0_fall, '0);
            chk("R8 reset ddr1 rise", d1_rise, '0);
            chk("R8 reset ddr1 fall", d1_fall, '0);
            return;
        end
        chk("R4 sdr fall quiet", s_fall, '0);
        n = k - 2;
        if (n >= 4) begin
            for (int g = 0; g < NG; g++)
                chk($sformatf("R2 sdr group %0d phase %0d", g, PH[g]),
                    s_rise & gmask(g), w_s(n) & gmask(g));
            chk("R3 sdr word", s_rise, w_s(n));
            if (n >= 7 && n <= 11) chk("R1 sdr group-only pattern", s_rise, w_s(n));
        end
        n = k - 3;
        if (n >= 4) begin
            for (int g = 0; g < NG; g++)
                chk($sformatf("R5 ddr second half group %0d", g),
                    d0_fall & gmask(g), w_df(n) & gmask(g));
            chk("R6 ddr first half", d0_rise, w_dr(n));
            chk("R6 ddr second half", d0_fall, w_df(n));
            chk("R7 delayed ddr first half", d1_rise, w_dr(n));
        end
        if (n - 1 >= 4) chk("R7 delayed ddr second half", d1_fall, w_df(n - 1));
    endtask

    initial begin
        void'($urandom(32'h5EED_0C1A));
        for (int n = 0; n < NW; n++) begin
            tx_s[n]  = rnd_word();
            tx_dr[n] = rnd_word();
            tx_df[n] = rnd_word();
        end
        // Directed corners: all ones, alternating, then one group at a time.
        tx_s[4] = '1;                 tx_dr[4] = '1;         tx_df[4] = '0;
        tx_s[5] = {20{2'b01}};        tx_dr[5] = '0;         tx_df[5] = '1;
        tx_s[6] = {20{2'b10}};        tx_dr[6] = {20{2'b10}}; tx_df[6] = {20{2'b01}};
        for (int g = 0; g < NG; g++) begin
            tx_s[7 + g]  = gmask(g);
            tx_dr[7 + g] = gmask(g);
            tx_df[7 + g] = ~gmask(g);
        end

        rst_n = 1'b0;
        sdr_line = '0;
        ddr_line = '0;
        for (int s = 0; s < TICKS; s++) begin
            clk    = (s % 4 == 0) || (s % 4 == 1);
            clk90  = (s % 4 == 1) || (s % 4 == 2);
            clk180 = (s % 4 == 2) || (s % 4 == 3);
            clk270 = (s % 4 == 3) || (s % 4 == 0);
            #1;
            if (s == 14) rst_n = 1'b1;
            drive(s);
            if (s % 4 == 2) check_cycle(s / 4);
            #4;
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R3 watchdog: got no completion expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule